// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Freeze and Request-to-Send Control

This block turns bytes into asynchronous serial frames. A producer hands it characters over a valid/ready byte interface. They wait in a three-entry queue in front of a shift register. Each character goes out as one low start bit, then seven or eight data bits with the least significant bit first, then one or two high stop bits. The line rests high between frames. Every bit lasts sixteen pulses of an oversampling strobe, so a single system clock serves any bit rate.

Software can pause output at a character boundary with the freeze input. While freeze is high, no new character is taken in. Characters already accepted still go out, and the line then goes quiet. Dropping freeze lets the next offered character through. A character can carry an end-of-buffer mark.

The request-to-send output has two policies. In the first, it follows pending traffic. In the second, it follows the enable alone. In both policies, it drops after a marked character has left.

Top module: `async_tx_freeze`

## Requirements
- R1: After reset, and whenever no character is queued or in flight, `txd` is high and `busy` is low. Directly after reset, `rts` is low and `in_ready` is high.
- R2: A frame is one low start bit, then the data bits least significant bit first, then high stop bits. Each bit holds for exactly 16 cycles in which `tick_en` is high.
- R3: Characters that are queued back to back follow each other with no idle gap. The start-to-start distance is (1 + data bits + stop bits) × 16 ticks.
- R4: When `char_len8` = 0, exactly seven data bits (bits 0..6) are sent and bit 7 of the character has no effect. When `char_len8` = 1, all eight bits are sent.
- R5: When `two_stop` = 0, one stop bit is sent. When `two_stop` = 1, two stop bits are sent.
- R6: Up to three accepted characters can wait while none is being shifted. `in_ready` is low while the queue is full. While `tx_enable` = 0, no new frame starts.
- R7: While `freeze` = 1, `in_ready` is low. Every character accepted before the freeze is still transmitted, and the line then stays idle.
- R8: A character offered during freeze is not taken. After `freeze` returns to 0, the next offered character is accepted and sent.
- R9: With `rts_always` = 0, `rts` is high while `tx_enable` = 1 and a character is queued or in flight. It goes low at the end of the last stop bit once nothing remains.
- R10: With `rts_always` = 1, `rts` equals `tx_enable` whether or not data is pending, except as stated in R11.
- R11: A character offered with `in_last` = 1 marks the end of a buffer. After its last stop bit, `rts` is low, even with `tx_enable` = 1, until the next character starts. This applies unless a next character starts in that same cycle.
- R12: While `tick_en` is low, an active frame does not advance and `txd` holds its value.
- R13: `busy` is high while any accepted character is still queued or being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oversampling strobe, 16 per bit |
| tx_enable | input | 1 | Allows frames to start; gates `rts` |
| freeze | input | 1 | Blocks intake; queue drains, then line idles |
| char_len8 | input | 1 | 1 = eight data bits, 0 = seven |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rts_always | input | 1 | 1 = `rts` follows enable, 0 = follows pending data |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character value |
| in_last | input | 1 | Offered character ends a buffer |
| in_ready | output | 1 | Character will be accepted this cycle |
| txd | output | 1 | Serial line, idle high |
| rts | output | 1 | Request-to-send |
| busy | output | 1 | Character queued or in flight |

## Verification
On every cycle, the assertions check several things. The queue never overflows or underflows. A load drives the line low on the next cycle. The line holds still whenever the strobe is low. The line is high whenever nothing is in flight. `rts` is low after the pending traffic ends in data-following mode, and after a marked character finishes.

Only the bench's scenarios can show the rest. This covers the bit values and their order on the wire, the seven-bit masking, the exact frame length in back-to-back bursts, and that a freeze loses no accepted character. It also covers that a character offered during freeze is only taken after release.

// File: rtl/atf_pkg.sv
package atf_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;

  // index of the final data bit for the selected character length
  function automatic logic [2:0] last_data_index(input logic len8);
    return len8 ? 3'd7 : 3'd6;
  endfunction

  // index of the final stop bit for the selected stop length
  function automatic logic last_stop_index(input logic two_stop);
    return two_stop;
  endfunction
endpackage

// File: rtl/atf_fifo.sv
module atf_fifo #(
  parameter int DEPTH = 3,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [WIDTH-1:0] slots [DEPTH];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WIDTH-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (push && wr_ptr == PW'(g)) slot_q <= wdata;
      end
      assign slots[g] = slot_q;
    end
  endgenerate

  assign rdata = slots[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/atf_shifter.sv
module atf_shifter
  import atf_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start_ok,
  input  logic              char_len8,
  input  logic              two_stop,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_last,
  output logic              load,
  output logic              txd,
  output logic              active,
  output logic              done_last
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);

  tx_state_e         state;
  logic [TW-1:0]     tick_cnt;
  logic [2:0]        bit_idx;
  logic              stop_idx;
  logic [CHAR_W-1:0] shreg;
  logic              last_q;

  // named events for the assertions and the queue
  logic bit_end, final_stop_end;
  assign bit_end        = tick_en && (state != ST_IDLE) && (tick_cnt == TICK_LAST);
  assign final_stop_end = bit_end && (state == ST_STOP) && (stop_idx == last_stop_index(two_stop));
  assign load           = start_ok && ((state == ST_IDLE) || final_stop_end);
  assign done_last      = final_stop_end && last_q;
  assign active         = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      shreg    <= '0;
      last_q   <= 1'b0;
    end else if (load) begin
      state    <= ST_START;
      tick_cnt <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      shreg    <= char_data;
      last_q   <= char_last;
    end else if (tick_en && state != ST_IDLE) begin
      if (tick_cnt != TICK_LAST) begin
        tick_cnt <= tick_cnt + TW'(1);
      end else begin
        tick_cnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == last_data_index(char_len8)) state <= ST_STOP;
            else bit_idx <= bit_idx + 3'd1;
          end
          ST_STOP: begin
            if (stop_idx == last_stop_index(two_stop)) state <= ST_IDLE;
            else stop_idx <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(txd));
endmodule

// File: rtl/atf_rts.sv
module atf_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_enable,
  input  logic rts_always,
  input  logic pending,
  input  logic load,
  input  logic done_last,
  output logic rts
);
  logic eob_hold;

  always_ff @(posedge clk) begin
    if (!rst_n)         eob_hold <= 1'b0;
    else if (load)      eob_hold <= 1'b0;
    else if (done_last) eob_hold <= 1'b1;
  end

  assign rts = tx_enable && !eob_hold && (rts_always || pending);

  assert_eob_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_last && !load) |=> !rts);
endmodule

// File: rtl/async_tx_freeze.sv
module async_tx_freeze
  import atf_pkg::*;
#(
  parameter int FIFO_DEPTH    = 3,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              tx_enable,
  input  logic              freeze,
  input  logic              char_len8,
  input  logic              two_stop,
  input  logic              rts_always,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              txd,
  output logic              rts,
  output logic              busy
);
  localparam int ENTRY_W = CHAR_W + 1;

  logic               push, fifo_full, fifo_empty;
  logic [ENTRY_W-1:0] head;
  logic               load, active, done_last;

  assign in_ready = !fifo_full && !freeze;
  assign push     = in_valid && in_ready;
  assign busy     = active || !fifo_empty;

  atf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata ({in_last, in_data}),
    .pop   (load),
    .rdata (head),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  atf_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start_ok  (!fifo_empty && tx_enable),
    .char_len8 (char_len8),
    .two_stop  (two_stop),
    .char_data (head[CHAR_W-1:0]),
    .char_last (head[CHAR_W]),
    .load      (load),
    .txd       (txd),
    .active    (active),
    .done_last (done_last)
  );

  atf_rts u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .rts_always (rts_always),
    .pending    (busy),
    .load       (load),
    .done_last  (done_last),
    .rts        (rts)
  );

  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_rts_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_always && $fell(busy)) |-> !rts);
endmodule

// File: tb/tb_async_tx_freeze.sv
module tb_async_tx_freeze;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b1, tx_enable = 1'b0, freeze = 1'b0;
  logic char_len8 = 1'b1, two_stop = 1'b0, rts_always = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, txd, rts, busy;

  async_tx_freeze dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_enable(tx_enable),
    .freeze(freeze), .char_len8(char_len8), .two_stop(two_stop),
    .rts_always(rts_always), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .txd(txd), .rts(rts), .busy(busy)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int prev_start = -1, last_interval = 0, frames_seen = 0;
  logic [7:0] exp_q[$];
  bit done_flag = 0;

  always @(posedge clk) cyc++;

  function automatic int frame_cycles(input logic len8, input logic two);
    return (1 + (len8 ? 8 : 7) + (two ? 2 : 1)) * 16;
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] c, input logic len8);
    return len8 ? c : (c & 8'h7F);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick_en) k++;
    end
    #2;
  endtask

  // line monitor: decodes frames by counting strobes
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] got;
        logic [7:0] e;
        got = 8'h00;
        if (prev_start >= 0) last_interval = cyc - prev_start;
        prev_start = cyc;
        wait_ticks(8);
        chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < (char_len8 ? 8 : 7); i++) begin
          wait_ticks(16);
          got[i] = txd;
        end
        for (int s = 0; s < (two_stop ? 2 : 1); s++) begin
          wait_ticks(16);
          chk(txd == 1'b1, "R5 stop bit", int'(txd), 1);
        end
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected frame", int'(got), -1);
        end else begin
          e = exp_q.pop_front();
          chk(got == keep_bits(e, char_len8), "R2/R4 data bits", int'(got), int'(keep_bits(e, char_len8)));
        end
        frames_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_up();
  end

  task automatic send(input logic [7:0] d, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic burst(input int n);
    @(negedge clk); tx_enable = 1'b0;
    for (int i = 0; i < n; i++) send(8'($urandom), 1'b0);
    @(negedge clk);
    chk(txd == 1'b1, "R6 no frame while disabled", int'(txd), 1);
    chk(busy == 1'b1, "R13 busy with queued chars", int'(busy), 1);
    tx_enable = 1'b1;
    drain();
  endtask

  initial begin
    int f0;
    logic okhold;
    logic held;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", int'(txd), 1);
    chk(rts == 1'b0, "R1 rts after reset", int'(rts), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R2/R9/R13: random eight-bit characters, data-following rts
    tx_enable = 1'b1;
    send(8'hA5, 1'b0);
    @(negedge clk);
    chk(busy == 1'b1, "R13 busy in flight", int'(busy), 1);
    chk(rts == 1'b1, "R9 rts with pending data", int'(rts), 1);
    for (int i = 0; i < 5; i++) send(8'($urandom), 1'b0);
    drain();
    chk(rts == 1'b0, "R9 rts after drain", int'(rts), 0);
    chk(busy == 1'b0, "R13 idle after drain", int'(busy), 0);
    chk(txd == 1'b1, "R1 idle line after drain", int'(txd), 1);

    // R6/R3: three queued while disabled, then back to back
    @(negedge clk); tx_enable = 1'b0;
    for (int i = 0; i < 3; i++) send(8'($urandom), 1'b0);
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R6 ready low when full", int'(in_ready), 0);
    chk(txd == 1'b1, "R6 no frame while disabled", int'(txd), 1);
    tx_enable = 1'b1;
    drain();
    chk(last_interval == frame_cycles(1, 0), "R3 back-to-back 8N1", last_interval, frame_cycles(1, 0));

    // R5: two stop bits
    two_stop = 1'b1;
    burst(3);
    chk(last_interval == frame_cycles(1, 1), "R5 two stop frame length", last_interval, frame_cycles(1, 1));
    two_stop = 1'b0;

    // R4: seven-bit characters, bit 7 both set and clear
    char_len8 = 1'b0;
    @(negedge clk); tx_enable = 1'b0;
    send(8'hD5, 1'b0); send(8'h2A, 1'b0); send(8'($urandom), 1'b0);
    @(negedge clk); tx_enable = 1'b1;
    drain();
    chk(last_interval == frame_cycles(0, 0), "R4 seven-bit frame length", last_interval, frame_cycles(0, 0));
    for (int i = 0; i < 3; i++) send(8'($urandom), 1'b0);
    drain();
    char_len8 = 1'b1;

    // R7/R8: freeze drains accepted characters and blocks intake
    f0 = frames_seen;
    for (int i = 0; i < 4; i++) send(8'($urandom), 1'b0);
    @(negedge clk); freeze = 1'b1; #1;
    chk(in_ready == 1'b0, "R7 ready low in freeze", int'(in_ready), 0);
    drain();
    chk(frames_seen == f0 + 4, "R7 accepted chars all sent", frames_seen, f0 + 4);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h3C;
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && txd == 1'b1, "R8 offer ignored while frozen", int'(busy), 0);
    chk(frames_seen == f0 + 4, "R8 no frame while frozen", frames_seen, f0 + 4);
    in_valid = 1'b0; freeze = 1'b0;
    send(8'h3C, 1'b0);
    drain();
    chk(frames_seen == f0 + 5, "R8 char sent after release", frames_seen, f0 + 5);

    // R10: enable-following rts
    @(negedge clk); rts_always = 1'b1;
    #1;
    chk(rts == 1'b1, "R10 rts high idle", int'(rts), 1);
    @(negedge clk); tx_enable = 1'b0; #1;
    chk(rts == 1'b0, "R10 rts low when disabled", int'(rts), 0);
    @(negedge clk); tx_enable = 1'b1;

    // R11: end-of-buffer mark
    send(8'h81, 1'b1);
    drain();
    chk(rts == 1'b0, "R11 rts low after marked char", int'(rts), 0);
    send(8'h18, 1'b0);
    @(negedge clk);
    while (!busy) @(negedge clk);
    chk(rts == 1'b1, "R11 rts back with next char", int'(rts), 1);
    drain();
    chk(rts == 1'b1, "R10 rts high after plain char", int'(rts), 1);

    // R12: strobe low freezes the line
    rts_always = 1'b0;
    send(8'h96, 1'b0);
    repeat (40) @(negedge clk);
    held = txd; okhold = 1'b1;
    tick_en = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (txd !== held || busy !== 1'b1) okhold = 1'b0;
    end
    chk(okhold, "R12 line held without strobe", int'(txd), int'(held));
    tick_en = 1'b1;
    drain();
    chk(exp_q.size() == 0, "R12 char completes after strobe returns", exp_q.size(), 0);

    finish_up();
  end
endmodule